// File: doc/BRIEF.md
# Paged Address Generation Unit

This unit forms 20-bit physical addresses for a small 16-bit processor core. It holds eight 16-bit address registers. Each one has its own 4-bit page register, which supplies the top four address bits. Register 0 serves as the program counter. A select input chooses one of two combinational paths to drive the single physical-address output:

- The operand path takes the chosen address register and its page. It merges a 4-bit instruction displacement into address bits 1 to 4 with a bitwise OR.
- The fetch path builds the address of the next instruction word. It uses the upper twelve bits of the program counter, the program counter's page, and a 3-bit slot field from the current instruction. The slot field picks one of eight word slots in an aligned block.

Because fetches ignore the low four bits of the program counter, those bits can carry a copy of the program page. A program-counter write that carries the page-load flag also loads the PC page register from bits 3:0 of the written value, on the same clock edge. A saved return address is therefore a single 16-bit value that can restore both the block and the page, so jumps reach the whole 20-bit space. The selected register's full 16-bit value is also presented on a read output, so the program counter can be copied into a data register.

Top module: `paged_agu`

## Requirements
- R1: A synchronous active-low reset clears every address register and every page register to zero. After reset the operand output for any register is 0x00000 and the read output is 0x0000.
- R2: On the operand path (path_sel = 0), phys_addr[19:16] equals the page register paired with reg_sel. phys_addr[15:5] equals bits 15:5 of the address register selected by reg_sel.
- R3: On the operand path, phys_addr[4:1] equals the selected register's bits 4:1 ORed with disp[3:0], where disp bit 0 lands on address bit 1. phys_addr[0] equals the register's bit 0, the high-byte flag.
- R4: On the fetch path (path_sel = 1), phys_addr[0] is 0 and phys_addr[3:1] equals slot. phys_addr[15:4] equals program-counter bits 15:4 and phys_addr[19:16] equals the PC page register. The values of reg_sel and disp have no effect on this output.
- R5: When areg_we is high at a clock edge, the register addressed by areg_waddr takes areg_wdata, and no other address register changes.
- R6: When page_we is high at a clock edge, the page register addressed by page_waddr takes page_wdata. This applies to register 0 too, provided no program-counter page load happens in the same cycle.
- R7: A write to address register 0 with pc_pgload high also loads the PC page register from areg_wdata[3:0] on the same edge.
- R8: If a program-counter page load and a page_we write to page register 0 fall in the same cycle, the program-counter page load wins.
- R9: A write to address register 0 with pc_pgload low leaves the PC page register unchanged.
- R10: pc_pgload has no effect on any page register when the address-register write targets a register other than 0.
- R11: areg_rdata always shows the full 16-bit contents of the address register selected by reg_sel, on either path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| path_sel | input | 1 | 0 = operand address, 1 = instruction fetch address |
| reg_sel | input | 3 | Address register used by the operand path and the read output |
| disp | input | 4 | Instruction displacement, ORed into address bits 4:1 |
| slot | input | 3 | Next-slot field of the current instruction |
| areg_we | input | 1 | Address-register write enable |
| areg_waddr | input | 3 | Address register to write |
| areg_wdata | input | 16 | Address-register write value |
| pc_pgload | input | 1 | On a write to register 0, also load its page from the value's bits 3:0 |
| page_we | input | 1 | Page-register write enable |
| page_waddr | input | 3 | Page register to write |
| page_wdata | input | 4 | Page-register write value |
| phys_addr | output | 20 | Physical address from the chosen path |
| areg_rdata | output | 16 | Contents of the address register chosen by reg_sel |

## Verification
Two register updates can meet on page register 0 in one cycle: a program-counter write that carries the page-load flag, and an explicit page-register write to page 0. The bench raises both enables on the same edge, with different page values in the two sources. It then reads the fetch address and expects the page taken from the low bits of the written program-counter value. The bench also repeats that program-counter load with page_we aimed at a different page register. Both updates must then land, which shows that the priority applies only on a true collision.

// File: rtl/pagu_pkg.sv
// Package: shared sizing and path encoding for the paged address generation unit.
// Assumes one page register per address register and register 0 as program counter.
package pagu_pkg;
    localparam int AW     = 16;                // address register width
    localparam int PW     = 4;                 // page register width
    localparam int NREG   = 8;                 // number of address registers
    localparam int RSEL_W = $clog2(NREG);      // register index width
    localparam int DISP_W = 4;                 // displacement width (ORed at bit 1)
    localparam int SLOT_W = 3;                 // instruction slot field width
    localparam int PHYS_W = AW + PW;           // physical address width

    typedef enum logic {
        PATH_OPERAND = 1'b0,
        PATH_FETCH   = 1'b1
    } path_e;
endpackage

// File: rtl/pagu_regfile.sv
// Module: address and page register file.
// Holds NREG address registers, each with a page register. Register 0 is the
// program counter: a write to it with pc_pgload also loads its page from the
// low PW bits of the written value, overriding a page write to page 0.
// Assumes synchronous active-low reset and one write per array per cycle.
module pagu_regfile #(
    parameter int AW     = pagu_pkg::AW,
    parameter int PW     = pagu_pkg::PW,
    parameter int NREG   = pagu_pkg::NREG,
    parameter int RSEL_W = pagu_pkg::RSEL_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       areg_we,
    input  logic [RSEL_W-1:0]          areg_waddr,
    input  logic [AW-1:0]              areg_wdata,
    input  logic                       pc_pgload,
    input  logic                       page_we,
    input  logic [RSEL_W-1:0]          page_waddr,
    input  logic [PW-1:0]              page_wdata,
    output logic [NREG-1:0][AW-1:0]    areg_q,
    output logic [NREG-1:0][PW-1:0]    page_q
);
    logic pc_page_hit;

    // Detect a program-counter write that also carries its page.
    always_comb begin
        pc_page_hit = areg_we && (areg_waddr == '0) && pc_pgload;
    end

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        // Address register g: cleared on reset, loaded on matching write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                areg_q[g] <= '0;
            end else if (areg_we && (areg_waddr == RSEL_W'(g))) begin
                areg_q[g] <= areg_wdata;
            end
        end

        if (g == 0) begin : g_pc_page
            // PC page: page load from PC write beats an explicit page write.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    page_q[g] <= '0;
                end else if (pc_page_hit) begin
                    page_q[g] <= areg_wdata[PW-1:0];
                end else if (page_we && (page_waddr == '0)) begin
                    page_q[g] <= page_wdata;
                end
            end
        end else begin : g_plain_page
            // Ordinary page register g: loaded only by the page write port.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    page_q[g] <= '0;
                end else if (page_we && (page_waddr == RSEL_W'(g))) begin
                    page_q[g] <= page_wdata;
                end
            end
        end
    end

    // R1: reset clears the program counter and its page.
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (areg_q[0] == '0) && (page_q[0] == '0));

    // R5: an address write lands in the addressed register.
    a_r5_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        areg_we |=> areg_q[$past(areg_waddr)] == $past(areg_wdata));

    // R7 and R8: a PC write with page load sets the PC page from its low bits.
    a_r7_pc_page_load: assert property (@(posedge clk) disable iff (!rst_n)
        (areg_we && (areg_waddr == '0) && pc_pgload)
        |=> page_q[0] == $past(areg_wdata[PW-1:0]));

    // R9: a PC write without page load and no page-0 write keeps the page.
    a_r9_page_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (areg_we && (areg_waddr == '0) && !pc_pgload &&
         !(page_we && (page_waddr == '0)))
        |=> $stable(page_q[0]));
endmodule

// File: rtl/pagu_read_mux.sv
// Module: selects one address register and its paired page register.
// Purely combinational; assumes reg_sel is always a valid index.
module pagu_read_mux #(
    parameter int AW     = pagu_pkg::AW,
    parameter int PW     = pagu_pkg::PW,
    parameter int NREG   = pagu_pkg::NREG,
    parameter int RSEL_W = pagu_pkg::RSEL_W
) (
    input  logic [NREG-1:0][AW-1:0] areg_q,
    input  logic [NREG-1:0][PW-1:0] page_q,
    input  logic [RSEL_W-1:0]       reg_sel,
    output logic [AW-1:0]           areg_sel,
    output logic [PW-1:0]           page_sel
);
    // Index the register arrays with the operand register select.
    always_comb begin
        areg_sel = areg_q[reg_sel];
        page_sel = page_q[reg_sel];
    end
endmodule

// File: rtl/pagu_operand_path.sv
// Module: operand address former.
// Merges the displacement into address bits DISP_W:1 with OR (no carry),
// keeps bit 0 (high-byte flag) and the upper bits, and prefixes the page.
// Assumes DISP_W + 1 < AW.
module pagu_operand_path #(
    parameter int AW     = pagu_pkg::AW,
    parameter int PW     = pagu_pkg::PW,
    parameter int DISP_W = pagu_pkg::DISP_W,
    localparam int PHYS_W = AW + PW
) (
    input  logic [AW-1:0]     areg,
    input  logic [PW-1:0]     page,
    input  logic [DISP_W-1:0] disp,
    output logic [PHYS_W-1:0] addr
);
    // Assemble page, upper bits, ORed displacement field and byte bit.
    always_comb begin
        addr = {page, areg[AW-1:DISP_W+1], areg[DISP_W:1] | disp, areg[0]};
    end
endmodule

// File: rtl/pagu_fetch_path.sv
// Module: instruction fetch address former.
// Takes the block address from the program counter's upper bits, the word
// slot from the instruction's slot field, forces the byte bit to zero and
// prefixes the program page. Assumes SLOT_W + 1 < AW.
module pagu_fetch_path #(
    parameter int AW     = pagu_pkg::AW,
    parameter int PW     = pagu_pkg::PW,
    parameter int SLOT_W = pagu_pkg::SLOT_W,
    localparam int BLK_W  = AW - SLOT_W - 1,
    localparam int PHYS_W = AW + PW
) (
    input  logic [BLK_W-1:0]  pc_block,
    input  logic [PW-1:0]     pc_page,
    input  logic [SLOT_W-1:0] slot,
    output logic [PHYS_W-1:0] addr
);
    // Assemble page, block, slot and a zero byte bit.
    always_comb begin
        addr = {pc_page, pc_block, slot, 1'b0};
    end
endmodule

// File: rtl/paged_agu.sv
// Module: paged address generation unit (top).
// Holds address/page register pairs and forms either an operand address or
// a next-instruction fetch address, chosen by path_sel. Outputs are
// combinational from register state and instruction fields.
// Assumes synchronous active-low reset; register 0 is the program counter.
module paged_agu #(
    parameter int AW     = pagu_pkg::AW,
    parameter int PW     = pagu_pkg::PW,
    parameter int NREG   = pagu_pkg::NREG,
    parameter int DISP_W = pagu_pkg::DISP_W,
    parameter int SLOT_W = pagu_pkg::SLOT_W,
    localparam int RSEL_W = $clog2(NREG),
    localparam int PHYS_W = AW + PW,
    localparam int BLK_LO = SLOT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              path_sel,
    input  logic [RSEL_W-1:0] reg_sel,
    input  logic [DISP_W-1:0] disp,
    input  logic [SLOT_W-1:0] slot,
    input  logic              areg_we,
    input  logic [RSEL_W-1:0] areg_waddr,
    input  logic [AW-1:0]     areg_wdata,
    input  logic              pc_pgload,
    input  logic              page_we,
    input  logic [RSEL_W-1:0] page_waddr,
    input  logic [PW-1:0]     page_wdata,
    output logic [PHYS_W-1:0] phys_addr,
    output logic [AW-1:0]     areg_rdata
);
    import pagu_pkg::*;

    logic [NREG-1:0][AW-1:0] areg_q;
    logic [NREG-1:0][PW-1:0] page_q;
    logic [AW-1:0]           areg_sel;
    logic [PW-1:0]           page_sel;
    logic [PHYS_W-1:0]       op_addr;
    logic [PHYS_W-1:0]       fetch_addr;
    path_e                   path;

    pagu_regfile #(.AW(AW), .PW(PW), .NREG(NREG), .RSEL_W(RSEL_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .areg_we    (areg_we),
        .areg_waddr (areg_waddr),
        .areg_wdata (areg_wdata),
        .pc_pgload  (pc_pgload),
        .page_we    (page_we),
        .page_waddr (page_waddr),
        .page_wdata (page_wdata),
        .areg_q     (areg_q),
        .page_q     (page_q)
    );

    pagu_read_mux #(.AW(AW), .PW(PW), .NREG(NREG), .RSEL_W(RSEL_W)) u_rmux (
        .areg_q   (areg_q),
        .page_q   (page_q),
        .reg_sel  (reg_sel),
        .areg_sel (areg_sel),
        .page_sel (page_sel)
    );

    pagu_operand_path #(.AW(AW), .PW(PW), .DISP_W(DISP_W)) u_opnd (
        .areg (areg_sel),
        .page (page_sel),
        .disp (disp),
        .addr (op_addr)
    );

    pagu_fetch_path #(.AW(AW), .PW(PW), .SLOT_W(SLOT_W)) u_fetch (
        .pc_block (areg_q[0][AW-1:BLK_LO]),
        .pc_page  (page_q[0]),
        .slot     (slot),
        .addr     (fetch_addr)
    );

    // Decode the path select into the shared enum.
    always_comb begin
        path = path_e'(path_sel);
    end

    // Drive the physical address from the chosen path.
    always_comb begin
        unique case (path)
            PATH_FETCH: phys_addr = fetch_addr;
            default:    phys_addr = op_addr;
        endcase
    end

    // Present the selected register for copies into the data path.
    always_comb begin
        areg_rdata = areg_sel;
    end

    // R4: fetch address carries the program-counter block and page.
    a_r4_fetch_block: assert property (@(posedge clk) disable iff (!rst_n)
        path_sel |-> (phys_addr[AW-1:BLK_LO] == areg_q[0][AW-1:BLK_LO]) &&
                     (phys_addr[PHYS_W-1:AW] == page_q[0]));

    // R4: fetch addresses are always word aligned.
    a_r4_fetch_even: assert property (@(posedge clk) disable iff (!rst_n)
        path_sel |-> !phys_addr[0]);

    // R2: operand address upper bits follow the selected register pair.
    a_r2_operand_page: assert property (@(posedge clk) disable iff (!rst_n)
        !path_sel |-> (phys_addr[PHYS_W-1:AW] == page_q[reg_sel]) &&
                      (phys_addr[AW-1:DISP_W+1] == areg_q[reg_sel][AW-1:DISP_W+1]));
endmodule

// File: tb/paged_agu_bench.sv
// Scoreboard bench: driver tasks keep a reference model of the register
// state, push expected outputs into a queue, and a monitor compares them
// at the falling clock edge.
module paged_agu_bench;
    typedef struct {
        string       tag;
        logic [19:0] exp_addr;
        logic [15:0] exp_rd;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        path_sel = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic [3:0]  disp = '0;
    logic [2:0]  slot = '0;
    logic        areg_we = 1'b0;
    logic [2:0]  areg_waddr = '0;
    logic [15:0] areg_wdata = '0;
    logic        pc_pgload = 1'b0;
    logic        page_we = 1'b0;
    logic [2:0]  page_waddr = '0;
    logic [3:0]  page_wdata = '0;
    logic [19:0] phys_addr;
    logic [15:0] areg_rdata;

    item_t       sb_q[$];
    logic [15:0] m_a[8];
    logic [3:0]  m_p[8];
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    paged_agu u_paged_agu (
        .clk(clk), .rst_n(rst_n), .path_sel(path_sel), .reg_sel(reg_sel),
        .disp(disp), .slot(slot), .areg_we(areg_we), .areg_waddr(areg_waddr),
        .areg_wdata(areg_wdata), .pc_pgload(pc_pgload), .page_we(page_we),
        .page_waddr(page_waddr), .page_wdata(page_wdata),
        .phys_addr(phys_addr), .areg_rdata(areg_rdata)
    );

    // Monitor: compare the oldest expected item at the falling edge.
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            n_cmp++;
            if (phys_addr !== it.exp_addr || areg_rdata !== it.exp_rd) begin
                n_bad++;
                $display("FAIL %s: addr=%h rd=%h expected addr=%h rd=%h",
                         it.tag, phys_addr, areg_rdata, it.exp_addr, it.exp_rd);
            end
        end
    end

    task automatic model_reset();
        for (int i = 0; i < 8; i++) begin
            m_a[i] = '0;
            m_p[i] = '0;
        end
    endtask

    // One-cycle write; the reference model follows the requirements.
    task automatic do_write(input logic aw, input logic [2:0] awa,
                            input logic [15:0] awd, input logic pgl,
                            input logic pw, input logic [2:0] pwa,
                            input logic [3:0] pwd);
        @(posedge clk); #1;
        areg_we = aw; areg_waddr = awa; areg_wdata = awd; pc_pgload = pgl;
        page_we = pw; page_waddr = pwa; page_wdata = pwd;
        @(posedge clk); #1;
        areg_we = 1'b0; pc_pgload = 1'b0; page_we = 1'b0;
        if (pw) m_p[pwa] = pwd;
        if (aw) begin
            m_a[awa] = awd;
            if (awa == 3'd0 && pgl) m_p[0] = awd[3:0];
        end
    endtask

    // Operand-path check: drive fields, push expected value (R2, R3, R11).
    task automatic chk_op(input string tag, input logic [2:0] r, input logic [3:0] d);
        item_t it;
        @(posedge clk); #1;
        path_sel = 1'b0; reg_sel = r; disp = d;
        it.tag = tag;
        it.exp_addr = {m_p[r], m_a[r][15:5], m_a[r][4:1] | d, m_a[r][0]};
        it.exp_rd = m_a[r];
        sb_q.push_back(it);
    endtask

    // Fetch-path check (R4): reg_sel and disp are driven to distractor values.
    task automatic chk_fetch(input string tag, input logic [2:0] s,
                             input logic [2:0] r, input logic [3:0] d);
        item_t it;
        @(posedge clk); #1;
        path_sel = 1'b1; slot = s; reg_sel = r; disp = d;
        it.tag = tag;
        it.exp_addr = {m_p[0], m_a[0][15:4], s, 1'b0};
        it.exp_rd = m_a[r];
        sb_q.push_back(it);
    endtask

    // Watchdog: a hung run counts as a failure and still summarises.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state
        chk_op("R1 reset operand r3", 3'd3, 4'h0);
        chk_fetch("R1 reset fetch", 3'd0, 3'd0, 4'h0);
        // R5: fill every address register, read each back
        for (int i = 0; i < 8; i++)
            do_write(1'b1, 3'(i), 16'h1111 * 16'(i + 1) ^ 16'h5A30, 1'b0, 1'b0, 3'd0, 4'h0);
        for (int i = 0; i < 8; i++)
            chk_op("R5 R11 areg readback", 3'(i), 4'h0);
        // R6: fill every page register
        for (int i = 0; i < 8; i++)
            do_write(1'b0, 3'd0, 16'h0, 1'b0, 1'b1, 3'(i), 4'(15 - i));
        for (int i = 0; i < 8; i++)
            chk_op("R2 R6 page readback", 3'(i), 4'h0);
        // R3: OR merge of displacement, byte bit preserved
        do_write(1'b1, 3'd5, 16'hC0AB, 1'b0, 1'b0, 3'd0, 4'h0);
        chk_op("R3 disp or overlap", 3'd5, 4'h5);
        chk_op("R3 disp all ones", 3'd5, 4'hF);
        do_write(1'b1, 3'd5, 16'h7FE0, 1'b0, 1'b0, 3'd0, 4'h0);
        chk_op("R3 disp no carry", 3'd5, 4'hA);
        chk_op("R3 disp top bit", 3'd5, 4'h8);
        // R4: fetch path, every slot, with distractors
        do_write(1'b1, 3'd0, 16'hBEEF, 1'b0, 1'b0, 3'd0, 4'h0);
        for (int s = 0; s < 8; s++)
            chk_fetch("R4 fetch slot", 3'(s), 3'(7 - s), 4'(s * 2 + 1));
        // R7: PC load carries the page
        do_write(1'b1, 3'd0, 16'hABC7, 1'b1, 1'b0, 3'd0, 4'h0);
        chk_fetch("R7 pc page load", 3'd2, 3'd4, 4'h3);
        chk_op("R7 pc operand view", 3'd0, 4'h0);
        // R8: collision with page write to page 0
        do_write(1'b1, 3'd0, 16'h1235, 1'b1, 1'b1, 3'd0, 4'h2);
        chk_fetch("R8 pc page load wins", 3'd6, 3'd1, 4'h0);
        // R8: no collision when page write targets another register
        do_write(1'b1, 3'd0, 16'h4449, 1'b1, 1'b1, 3'd6, 4'h3);
        chk_fetch("R8 both land pc page", 3'd1, 3'd0, 4'h0);
        chk_op("R8 both land page6", 3'd6, 4'h0);
        // R9: PC write without flag keeps the page
        do_write(1'b1, 3'd0, 16'h8882, 1'b0, 1'b0, 3'd0, 4'h0);
        chk_fetch("R9 page kept", 3'd7, 3'd0, 4'h0);
        // R10: flag ignored for non-PC writes
        do_write(1'b1, 3'd3, 16'h000D, 1'b1, 1'b0, 3'd0, 4'h0);
        chk_fetch("R10 pc page untouched", 3'd0, 3'd3, 4'h0);
        chk_op("R10 reg3 page untouched", 3'd3, 4'h0);
        // R6: explicit page-0 write without a PC load
        do_write(1'b0, 3'd0, 16'h0, 1'b0, 1'b1, 3'd0, 4'hC);
        chk_fetch("R6 page0 write", 3'd5, 3'd2, 4'h0);
        // R1: mid-run reset clears everything
        @(posedge clk); #1 rst_n = 1'b0;
        @(posedge clk); #1 rst_n = 1'b1;
        model_reset();
        chk_op("R1 reset clears r6", 3'd6, 4'h0);
        chk_fetch("R1 reset clears pc", 3'd4, 3'd0, 4'h0);
        @(posedge clk); @(posedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule